// File: doc/BRIEF.md
# Receiver Queue Request Arbiter

Inside one receiver of a torus router, several packet queues hold a packet at their head that wants to move on: a set of adaptive virtual channels, a deadlock-escape channel, a high-priority channel and a cut-through bypass path. Only one of them may forward its request to the output side in any cycle. This block decides which one. It grants the winner with a one-hot vector in the same cycle as the requests are presented.

The order of choice is fixed at the top and mixed below it. Any queue that flags its head packet as high priority beats every other queue. Without such a packet, each cycle is one of two kinds, set by an 8-bit programmable ratio. On a longest-queue cycle, the queue whose 2-bit fill level is highest wins. On a random cycle, any requesting queue may win. A pseudo-random rotating start point breaks ties and makes the random choice. The bypass path sits below every buffered queue unless its packet is high priority.

Top module: `rx_vc_arbiter`

## Requirements
- R1: `gnt_o` has at most one bit set in every cycle.
- R2: When no bit of `req_i` is set, `gnt_o` is zero. The grant is combinational from the current inputs and is not held into later cycles.
- R3: A bit of `gnt_o` is set only for a queue whose `req_i` bit is set. A queue that is the only requester is granted.
- R4: If any requesting queue has its `hipri_i` bit set, the grant goes to one of the requesting high-priority queues, whatever the fill levels.
- R5: When more than one requester is high priority, each of them can win. The bypass queue takes part on equal terms when it is high priority.
- R6: On a longest-queue cycle with no high-priority requester, the winner is a non-bypass requester whose fill level is the highest among the non-bypass requesters. Queue i has its fill level on `fill_i[2*i+1:2*i]`, and 3 means fullest.
- R7: Reset clears an 8-bit cycle counter, which then advances by one on every clock edge and wraps from 255 to 0. A cycle is a longest-queue cycle exactly when the counter value is below `slq_frac_i`, so N means N of every 256 cycles. The value 0 makes every cycle a random cycle.
- R8: On a random cycle with no high-priority requester, the winner is any non-bypass requester, so a queue with a lower fill level can win.
- R9: The bypass queue is the highest index, NUM_Q-1. Without a high-priority flag it is granted only when no other queue requests.
- R10: Requesters tied on the highest fill level all win within a bounded run of cycles. No tied queue is starved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_Q | Head-of-queue request per queue, bypass at NUM_Q-1 |
| hipri_i | input | NUM_Q | Head packet is high priority, per queue |
| fill_i | input | NUM_Q*FILL_W | Fill level per queue, queue i at bits [FILL_W*i +: FILL_W] |
| slq_frac_i | input | 8 | Longest-queue cycles per 256 cycles |
| gnt_o | output | NUM_Q | One-hot grant, zero when idle |

## Verification
The single-requester pattern walks every queue, including the bypass queue, and shows that each index is routed to its own grant bit. A high-priority queue with an empty fill level is set against a full normal queue, which separates strict priority from longest-queue choice. Distinct fill levels are then run with the ratio at 128 and at 0. The bench tracks the cycle counter from reset, so it can tell a correct longest-queue pick from a random one and show that random cycles really do pick lower-filled queues. Equal-fill and multiple-high-priority patterns over hundreds of cycles show that the rotation reaches every tied queue.

// File: rtl/rxarb_pkg.sv
package rxarb_pkg;
  localparam int LFSR_W    = 16;
  localparam int PHASE_W   = 8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // maximal-length Fibonacci LFSR, taps 16,14,13,11
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/rxarb_sched.sv
module rxarb_sched
  import rxarb_pkg::*;
#(
  parameter int NUM_Q = 5,
  localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] slq_frac_i,
  output logic               slq_cycle_o,
  output logic [IDX_W-1:0]   start_o
);
  logic [PHASE_W-1:0] phase_q;
  logic [LFSR_W-1:0]  lfsr_q;
  logic [IDX_W-1:0]   idx_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      lfsr_q  <= LFSR_SEED;
    end else begin
      phase_q <= phase_q + 1'b1;
      lfsr_q  <= lfsr_next(lfsr_q);
    end
  end

  assign slq_cycle_o = (phase_q < slq_frac_i);
  assign idx_raw     = lfsr_q[IDX_W-1:0];
  // fold out-of-range values back into 0..NUM_Q-1
  assign start_o = (int'(idx_raw) >= NUM_Q) ? IDX_W'(int'(idx_raw) - NUM_Q) : idx_raw;

  assert_lfsr_live_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
  assert_start_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(start_o) < NUM_Q);
endmodule

// File: rtl/rxarb_maxfill.sv
module rxarb_maxfill #(
  parameter int NUM_Q  = 5,
  parameter int FILL_W = 2
) (
  input  logic [NUM_Q-1:0]        mask_i,
  input  logic [NUM_Q*FILL_W-1:0] fill_i,
  output logic [NUM_Q-1:0]        top_o
);
  logic [FILL_W-1:0] max_fill;

  always_comb begin
    max_fill = '0;
    for (int i = 0; i < NUM_Q; i++)
      if (mask_i[i] && fill_i[i*FILL_W +: FILL_W] > max_fill)
        max_fill = fill_i[i*FILL_W +: FILL_W];
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : g_top
    assign top_o[g] = mask_i[g] && (fill_i[g*FILL_W +: FILL_W] == max_fill);
  end
endmodule

// File: rtl/rxarb_rot_pick.sv
module rxarb_rot_pick #(
  parameter int NUM_Q = 5,
  localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic [NUM_Q-1:0] cand_i,
  input  logic [IDX_W-1:0] start_i,
  output logic [NUM_Q-1:0] gnt_o
);
  always_comb begin
    int  idx;
    logic found;
    gnt_o = '0;
    found = 1'b0;
    for (int k = 0; k < NUM_Q; k++) begin
      idx = int'(start_i) + k;
      if (idx >= NUM_Q) idx = idx - NUM_Q;
      if (!found && cand_i[idx]) begin
        gnt_o[idx] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_vc_arbiter.sv
module rx_vc_arbiter #(
  parameter int NUM_Q  = 5,
  parameter int FILL_W = 2,
  localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int BYP   = NUM_Q - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_Q-1:0]        req_i,
  input  logic [NUM_Q-1:0]        hipri_i,
  input  logic [NUM_Q*FILL_W-1:0] fill_i,
  input  logic [7:0]              slq_frac_i,
  output logic [NUM_Q-1:0]        gnt_o
);
  localparam logic [NUM_Q-1:0] BYP_BIT = NUM_Q'(1) << BYP;

  logic             slq_cycle;
  logic [IDX_W-1:0] start;
  logic [NUM_Q-1:0] hp_req, nb_req, top_req, cand;

  rxarb_sched #(.NUM_Q(NUM_Q)) u_sched (
    .clk_i, .rst_ni, .slq_frac_i,
    .slq_cycle_o(slq_cycle), .start_o(start)
  );

  assign hp_req = req_i & hipri_i;
  assign nb_req = req_i & ~BYP_BIT;

  rxarb_maxfill #(.NUM_Q(NUM_Q), .FILL_W(FILL_W)) u_maxfill (
    .mask_i(nb_req), .fill_i, .top_o(top_req)
  );

  always_comb begin
    if (|hp_req)      cand = hp_req;
    else if (|nb_req) cand = slq_cycle ? top_req : nb_req;
    else              cand = req_i;  // bypass alone, or nothing
  end

  rxarb_rot_pick #(.NUM_Q(NUM_Q)) u_pick (
    .cand_i(cand), .start_i(start), .gnt_o
  );

  // winner fill is not below any other non-bypass requester
  logic slq_beaten;
  always_comb begin
    slq_beaten = 1'b0;
    for (int w = 0; w < NUM_Q; w++)
      for (int o = 0; o < BYP; o++)
        if (gnt_o[w] && req_i[o] &&
            fill_i[o*FILL_W +: FILL_W] > fill_i[w*FILL_W +: FILL_W])
          slq_beaten = 1'b1;
  end

  assert_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |-> (gnt_o == '0));
  assert_subset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  assert_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> (gnt_o != '0));
  assert_hipri_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hp_req != '0) |-> ((gnt_o & hp_req) != '0));
  assert_slq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slq_cycle && hp_req == '0 && nb_req != '0) |-> !slq_beaten);
  assert_bypass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o[BYP] |-> (hipri_i[BYP] || nb_req == '0));
endmodule

// File: tb/rx_vc_arbiter_test.sv
module rx_vc_arbiter_test;
  localparam int NQ = 5;
  localparam int BYP = NQ - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NQ-1:0] req_i = '0;
  logic [NQ-1:0] hipri_i = '0;
  logic [2*NQ-1:0] fill_i = '0;
  logic [7:0]    slq_frac_i = 8'd0;
  logic [NQ-1:0] gnt_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] ph;

  rx_vc_arbiter #(.NUM_Q(NQ), .FILL_W(2)) uut (
    .clk_i, .rst_ni, .req_i, .hipri_i, .fill_i, .slq_frac_i, .gnt_o
  );

  always #5 clk_i = ~clk_i;

  // bench model of the cycle counter (R7)
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ph <= '0;
    else         ph <= ph + 8'd1;

  task automatic chk(input logic ok, input string tag, input logic [NQ-1:0] act,
                     input logic [NQ-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: gnt actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic set_fill(input int q, input logic [1:0] f);
    fill_i[2*q +: 2] = f;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(gnt_o == '0, "R2 reset idle", gnt_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(gnt_o == '0, "R2 idle after reset", gnt_o, '0);
  endtask

  task automatic t_single();
    for (int q = 0; q < NQ; q++) begin
      req_i = NQ'(1) << q;
      @(negedge clk_i);
      chk(gnt_o == req_i, "R3 sole requester", gnt_o, req_i);
      if (q == BYP) chk(gnt_o[BYP], "R9 bypass alone wins", gnt_o, req_i);
    end
    req_i = '0;
    #1;
    chk(gnt_o == '0, "R2 grant drops with request", gnt_o, '0);
  endtask

  task automatic t_hipri();
    fill_i = '0;
    set_fill(0, 2'd3); set_fill(1, 2'd0);
    req_i = 5'b00011; hipri_i = 5'b00010; slq_frac_i = 8'd255;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk_i);
      chk(gnt_o == 5'b00010, "R4 high priority beats full queue", gnt_o, 5'b00010);
    end
    req_i = 5'b10001; hipri_i = 5'b10000;
    @(negedge clk_i);
    chk(gnt_o == 5'b10000, "R9 high-priority bypass wins", gnt_o, 5'b10000);
    req_i = 5'b11111; hipri_i = 5'b10100;
    begin
      logic [NQ-1:0] seen = '0;
      for (int c = 0; c < 256; c++) begin
        @(negedge clk_i);
        seen |= gnt_o;
        if ((gnt_o & ~hipri_i) != '0 || !$onehot(gnt_o))
          chk(1'b0, "R4 winner not high priority", gnt_o, hipri_i);
      end
      chk(seen == 5'b10100, "R5 every high-priority queue wins", seen, 5'b10100);
    end
    hipri_i = '0; req_i = '0;
  endtask

  task automatic t_mix(input logic [7:0] frac, input string tag);
    logic other;
    other = 1'b0;
    fill_i = '0;
    set_fill(0, 2'd1); set_fill(1, 2'd0); set_fill(2, 2'd3); set_fill(3, 2'd2);
    set_fill(BYP, 2'd3);
    req_i = 5'b11101; slq_frac_i = frac;
    for (int c = 0; c < 256; c++) begin
      @(negedge clk_i);
      if (!$onehot(gnt_o)) chk(1'b0, "R1 not one-hot", gnt_o, 5'b00100);
      if (gnt_o[BYP]) chk(1'b0, "R9 bypass beat buffered queue", gnt_o, 5'b00100);
      if (ph < frac) begin
        if (gnt_o != 5'b00100) chk(1'b0, "R6/R7 longest queue on SLQ cycle", gnt_o, 5'b00100);
      end else if (gnt_o != 5'b00100) other = 1'b1;
    end
    chk(other, tag, gnt_o, 5'b01001);
    req_i = '0;
  endtask

  task automatic t_ties();
    logic [NQ-1:0] seen;
    seen = '0;
    fill_i = '0;
    for (int q = 0; q < NQ; q++) set_fill(q, 2'd3);
    set_fill(1, 2'd1);
    req_i = 5'b11111; slq_frac_i = 8'd255;
    for (int c = 0; c < 256; c++) begin
      @(negedge clk_i);
      seen |= gnt_o;
      if (ph < 8'd255 && (gnt_o & 5'b01101) == '0)
        chk(1'b0, "R6 tie winner not among fullest", gnt_o, 5'b01101);
    end
    chk(seen[0] && seen[2] && seen[3], "R10 tied queues all win", seen, 5'b01101);
    chk(!seen[BYP], "R9 bypass never wins with others", seen, 5'b01101);
    req_i = '0;
  endtask

  task automatic t_phase();
    // R7: counter wraps; with N=1 only phase 0 is a longest-queue cycle
    fill_i = '0;
    set_fill(0, 2'd0); set_fill(1, 2'd3);
    req_i = 5'b00011; slq_frac_i = 8'd1;
    while (ph != 8'd0) @(negedge clk_i);
    chk(gnt_o == 5'b00010, "R7 phase 0 is SLQ cycle", gnt_o, 5'b00010);
    req_i = '0;
  endtask

  initial begin
    t_reset();
    t_single();
    t_hipri();
    t_mix(8'd128, "R8 random cycles pick lower queues");
    t_mix(8'd0, "R8 ratio zero never pure SLQ");
    t_ties();
    t_phase();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule